// File: doc/BRIEF.md
# Successive-Approximation Slice Sequencer

This block sequences one converter slice of a time-interleaved successive-approximation converter. After a start pulse it runs a fixed schedule of `RES_W + 5` clock cycles, 16 at the default width. The first four cycles handle the analog set-up. A zero-reference sample comes first, then an offset comparison, then a gain-calibration comparison, then the sample of the analog input. Next come `RES_W` cycles of bit decisions, most significant bit first. The final cycle hands the finished word to the downstream output selector.

The analog comparator and the trial DAC are outside the block. In every decision cycle the block drives the trial code and reads back one comparator bit. A comparator bit of 1 means the input is at or above the trial level. The comparator bit from the offset-comparison slot also feeds a saturating signed counter. Its sign tells the external trim circuit which way to step the offset correction.

The result leaves as a word qualified by a one-cycle valid strobe. There is no back-pressure. The downstream selector visits each slice at a fixed time, so it must take the word in the transfer cycle. The word stays on `res_o` until the next input sample cycle begins a new search.

Top module: `sar_slice_ctrl`

## Requirements
- R1: After reset, every strobe is low, `dac_code_o` is zero, `res_valid_o` is low and `trim_cnt_o` is zero.
- R2: A start pulse seen while idle makes `samp_zero_o` high for exactly one cycle, in the cycle that follows the start.
- R3: After the zero-sample cycle, `az_cmp_o`, `cal_cmp_o` and `samp_in_o` are each high for one cycle, in that order.
- R4: There are `RES_W` decision cycles, and decision cycle k (k = 0 first) tests bit `RES_W-1-k`. In each one, `dac_code_o` holds the bits already decided above the tested bit, a 1 in the tested bit, and zeros below it. Outside the decision cycles `dac_code_o` is zero.
- R5: A comparator bit of 1 in a decision cycle keeps the tested bit at 1. A 0 clears it. The decision takes effect for the next lower trial.
- R6: In the last schedule cycle `res_valid_o` is high for one cycle, and `res_o` equals the decided bits. With an ideal comparator this equals the input code.
- R7: A start pulse in any schedule cycle other than the last is ignored. The schedule still runs every cycle in order.
- R8: A start pulse in the last schedule cycle begins a new schedule in the very next cycle, with no gap. Without one, the block goes idle and all strobes stay low.
- R9: In each offset-comparison cycle, `trim_cnt_o` rises by one on a comparator 1 and falls by one on a 0. It saturates at `2^(TRIM_W-1)-1` and `-2^(TRIM_W-1)`, and it is unchanged in every other cycle.
- R10: `trim_neg_o` is high exactly when `trim_cnt_o` is negative.
- R11: At most one of `samp_zero_o`, `az_cmp_o`, `cal_cmp_o`, `samp_in_o`, `res_valid_o` and the decision-cycle condition is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Phase-start pulse from the interleave timing generator |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial level |
| samp_zero_o | output | 1 | Sample zero reference |
| az_cmp_o | output | 1 | Offset comparison slot |
| cal_cmp_o | output | 1 | Gain-calibration comparison slot |
| samp_in_o | output | 1 | Sample analog input |
| dac_code_o | output | RES_W | Trial code to the DAC |
| res_valid_o | output | 1 | Result transfer strobe |
| res_o | output | RES_W | Result word |
| trim_cnt_o | output | TRIM_W | Signed offset-trim accumulator |
| trim_neg_o | output | 1 | Trim direction (sign of accumulator) |

## Verification
Two functions can fall in the same cycle: the result transfer of one conversion and the acceptance of the start for the next. The bench raises the start pulse in the transfer cycle for most conversions. It then checks that the valid word is correct in that cycle and that the zero-sample strobe follows in the very next cycle. In a subset of conversions the start is also held high through every earlier cycle, to show that an early start cannot shorten or reorder the schedule. A sweep over every input code, driven by an ideal comparator model, checks each trial code and each result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Fixed schedule slots (cycle numbers minus one)
  localparam int PH_ZERO = 0;
  localparam int PH_AZ   = 1;
  localparam int PH_CAL  = 2;
  localparam int PH_SIN  = 3;
  localparam int PH_BIT0 = 4;

  typedef struct packed {
    logic samp_zero;
    logic az_cmp;
    logic cal_cmp;
    logic samp_in;
    logic bit_en;
    logic xfer;
  } strobe_t;
endpackage

// File: rtl/sar_sched.sv
module sar_sched #(
  parameter int RES_W = 11,
  localparam int SCHED_LEN = RES_W + 5,
  localparam int PH_W = $clog2(SCHED_LEN),
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output sar_pkg::strobe_t   stb_o,
  output logic [IDX_W-1:0]   bit_idx_o
);
  import sar_pkg::*;
  localparam int PH_XFER = SCHED_LEN - 1;

  logic            busy;
  logic [PH_W-1:0] ph;
  logic            at_end;

  assign at_end = busy && (ph == PH_W'(PH_XFER));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (!busy || at_end) begin
      busy <= start_i;
      if (start_i) ph <= '0;
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

  always_comb begin
    stb_o.samp_zero = busy && (ph == PH_W'(PH_ZERO));
    stb_o.az_cmp    = busy && (ph == PH_W'(PH_AZ));
    stb_o.cal_cmp   = busy && (ph == PH_W'(PH_CAL));
    stb_o.samp_in   = busy && (ph == PH_W'(PH_SIN));
    stb_o.bit_en    = busy && (ph >= PH_W'(PH_BIT0)) && (ph < PH_W'(PH_XFER));
    stb_o.xfer      = at_end;
    bit_idx_o       = IDX_W'(RES_W - 1 - (int'(ph) - PH_BIT0));
  end

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> (busy && ph == $past(ph) + PH_W'(1)));
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!busy || at_end) && start_i) |=> stb_o.samp_zero);
  p_idle_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !start_i) |=> !busy);
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_o.samp_zero, stb_o.az_cmp, stb_o.cal_cmp,
              stb_o.samp_in, stb_o.bit_en, stb_o.xfer}));
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_W = 11,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             bit_en_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load_i) begin
      code_d = MSB_ONLY;
    end else if (bit_en_i) begin
      for (int i = 0; i < RES_W; i++) begin
        if (int'(bit_idx_i) == i) code_d[i] = cmp_i;
        if (int'(bit_idx_i) == i + 1) code_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  p_msb_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (code_o == MSB_ONLY));
  p_bit_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && cmp_i) |=> code_o[$past(bit_idx_i)]);
  p_bit_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && !cmp_i) |=> !code_o[$past(bit_idx_i)]);
endmodule

// File: rtl/sar_trim.sv
module sar_trim #(
  parameter int TRIM_W  = 6,
  parameter bit TRIM_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     az_en_i,
  input  logic                     cmp_i,
  output logic signed [TRIM_W-1:0] cnt_o
);
  localparam logic signed [TRIM_W-1:0] CNT_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] CNT_MIN = {1'b1, {(TRIM_W-1){1'b0}}};

  generate
    if (TRIM_EN) begin : g_cnt
      logic signed [TRIM_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (az_en_i) begin
          if (cmp_i && cnt_q != CNT_MAX)       cnt_q <= cnt_q + TRIM_W'(1);
          else if (!cmp_i && cnt_q != CNT_MIN) cnt_q <= cnt_q - TRIM_W'(1);
        end
      end
      assign cnt_o = cnt_q;

      p_trim_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !az_en_i |=> $stable(cnt_o));
      p_trim_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (az_en_i && cmp_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + TRIM_W'(1)));
      p_trim_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (az_en_i && !cmp_i && cnt_o != CNT_MIN) |=> (cnt_o == $past(cnt_o) - TRIM_W'(1)));
    end else begin : g_none
      assign cnt_o = '0;
    end
  endgenerate
endmodule

// File: rtl/sar_slice_ctrl.sv
module sar_slice_ctrl #(
  parameter int RES_W   = 11,
  parameter int TRIM_W  = 6,
  parameter bit TRIM_EN = 1'b1,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              samp_zero_o,
  output logic              az_cmp_o,
  output logic              cal_cmp_o,
  output logic              samp_in_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_o,
  output logic [TRIM_W-1:0] trim_cnt_o,
  output logic              trim_neg_o
);
  import sar_pkg::*;

  strobe_t                  stb;
  logic [IDX_W-1:0]         bit_idx;
  logic [RES_W-1:0]         code;
  logic signed [TRIM_W-1:0] cnt;

  sar_sched #(.RES_W(RES_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .stb_o(stb), .bit_idx_o(bit_idx)
  );

  sar_reg #(.RES_W(RES_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load_i(stb.samp_in), .bit_en_i(stb.bit_en),
    .bit_idx_i(bit_idx), .cmp_i(cmp_i), .code_o(code)
  );

  sar_trim #(.TRIM_W(TRIM_W), .TRIM_EN(TRIM_EN)) u_trim (
    .clk(clk), .rst_n(rst_n), .az_en_i(stb.az_cmp), .cmp_i(cmp_i), .cnt_o(cnt)
  );

  assign samp_zero_o = stb.samp_zero;
  assign az_cmp_o    = stb.az_cmp;
  assign cal_cmp_o   = stb.cal_cmp;
  assign samp_in_o   = stb.samp_in;
  assign dac_code_o  = stb.bit_en ? code : '0;
  assign res_valid_o = stb.xfer;
  assign res_o       = code;
  assign trim_cnt_o  = cnt;
  assign trim_neg_o  = cnt[TRIM_W-1];

  p_dac_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_zero_o || az_cmp_o || cal_cmp_o || samp_in_o || res_valid_o) |-> (dac_code_o == '0));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);
endmodule

// File: tb/sar_slice_ctrl_bench.sv
module sar_slice_ctrl_bench;
  localparam int RES_W  = 11;
  localparam int TRIM_W = 6;
  localparam int CMAX   = (1 << (TRIM_W - 1)) - 1;
  localparam int CMIN   = -(1 << (TRIM_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i = 1'b0;
  logic samp_zero_o, az_cmp_o, cal_cmp_o, samp_in_o, res_valid_o, trim_neg_o;
  logic [RES_W-1:0]  dac_code_o, res_o;
  logic [TRIM_W-1:0] trim_cnt_o;

  int checks = 0;
  int errors = 0;
  int model_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_slice_ctrl #(.RES_W(RES_W), .TRIM_W(TRIM_W), .TRIM_EN(1'b1)) u_sar_slice_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .samp_zero_o(samp_zero_o), .az_cmp_o(az_cmp_o), .cal_cmp_o(cal_cmp_o),
    .samp_in_o(samp_in_o), .dac_code_o(dac_code_o), .res_valid_o(res_valid_o),
    .res_o(res_o), .trim_cnt_o(trim_cnt_o), .trim_neg_o(trim_neg_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int strobes();
    return {27'd0, samp_zero_o, az_cmp_o, cal_cmp_o, samp_in_o, res_valid_o};
  endfunction

  task automatic chk_idle(input string req);
    chk(strobes() == 0 && dac_code_o == '0, req, strobes(), 0);
  endtask

  task automatic chk_trim();
    int act;
    act = int'($signed(trim_cnt_o));
    chk(act == model_cnt, "R9 trim count", act, model_cnt);
    chk(trim_neg_o == (model_cnt < 0), "R10 trim sign", int'(trim_neg_o), int'(model_cnt < 0));
  endtask

  // One schedule; the start for it was raised in the previous negedge.
  task automatic run_conv(input int v, input bit hold, input bit chain, input bit az_bit);
    for (int c = 1; c <= RES_W + 5; c++) begin
      @(negedge clk);
      if (c == 1) chk(strobes() == 16, "R2 zero sample", strobes(), 16);
      else if (c == 2) chk(strobes() == 8, "R3 offset compare", strobes(), 8);
      else if (c == 3) begin
        chk(strobes() == 4, "R3 calibration compare", strobes(), 4);
        chk_trim();
      end
      else if (c == 4) chk(strobes() == 2, "R3 input sample", strobes(), 2);
      else if (c <= RES_W + 4) begin
        int b, e;
        b = RES_W + 4 - c;
        e = ((v >> (b + 1)) << (b + 1)) | (1 << b);
        chk(int'(dac_code_o) == e && strobes() == 0, "R4 R5 trial code", int'(dac_code_o), e);
        cmp_i = (v >= e);
      end else begin
        chk(res_valid_o == 1'b1 && strobes() == 1, "R6 transfer strobe", strobes(), 1);
        chk(int'(res_o) == v, "R6 result word", int'(res_o), v);
      end
      if (c == 2) begin
        cmp_i = az_bit;
        if (az_bit && model_cnt < CMAX) model_cnt++;
        else if (!az_bit && model_cnt > CMIN) model_cnt--;
      end
      start_i = (c == RES_W + 5) ? chain : hold;  // R7 held start, R8 chained start
    end
  endtask

  initial begin
    bit chain_prev;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset strobes");
    chk(res_valid_o == 1'b0 && trim_cnt_o == '0, "R1 reset outputs", int'(trim_cnt_o), 0);
    rst_n = 1'b1;
    chain_prev = 1'b0;
    for (int v = 0; v < (1 << RES_W); v++) begin
      bit hold, chain, az;
      hold  = (v % 5 == 1);
      chain = (v % 3 != 2);
      az    = (v < 40) ? 1'b1 : (v < 120) ? 1'b0 : v[0];
      if (!chain_prev) begin
        @(negedge clk);
        if (v != 0) chk_idle("R8 idle after transfer");
        chk_trim();
        start_i = 1'b1;
      end
      run_conv(v, hold, chain, az);
      chain_prev = chain;
    end
    @(negedge clk);
    start_i = 1'b0;
    repeat (RES_W + 6) @(negedge clk);
    chk_idle("R8 final idle");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule